// File: doc/BRIEF.md
# Dual Leaky Bucket Frame Policer

The block meters a stream of frames against a peak bucket and, when enabled, a committed bucket, and returns a colour for every frame: green, yellow or discard. A frame is announced by a one-cycle start pulse carrying its length in bytes. Each bucket keeps a 23-bit fill level. An accepted frame raises the fill by its charge, and a periodic drain tick lowers it by a configured rate. A frame is judged only on the fill it sees when it arrives, so a single accepted frame may carry a bucket past its limit.

The block has four metering modes. Two count bytes: one adds a configurable inter-frame gap to every frame and the other does not. Two count frames, in tenths of a frame, with a coarse and a fine rate resolution. The committed bucket can pass the drain it cannot use on to the peak bucket. Either bucket can be forced full. A reserved peak setting turns policing off.

Top module: `dlb_policer`

## Requirements
- R1: After reset `verdict_valid` is low and both fills are zero, so the first frame after reset is accepted by every bucket whose limit is zero or more.
- R2: A frame start in cycle n gives `verdict_valid` high in cycle n+1 only, with `verdict` coded 0 = green, 1 = yellow, 2 = discard.
- R3: A frame conforms to a bucket when that bucket's fill is at most its limit on arrival. An accepted frame adds its whole charge, even when this carries the fill above the limit.
- R4: The charge is the frame length plus `cfg_gap` bytes in mode 0 (line), the frame length in mode 1 (data), and 10 tenth-frames in modes 2 and 3.
- R5: A bucket limit is its burst value times 4096 bytes in modes 0 and 1, times 328 tenth-frames in mode 2, and times 3 tenth-frames in mode 3.
- R6: A tick with drain enabled lowers each fill by its rate times BIT_DRAIN (modes 0 and 1) or times FRM_DRAIN (modes 2 and 3), and never below zero. In mode 3 drain is enabled only on every LO_DIV-th tick counted from reset. In the other modes it is enabled on every tick.
- R7: A frame that fails the peak bucket is discarded. Otherwise it is green if the committed bucket is off or conforms, and yellow if it does not.
- R8: A green frame charges the peak bucket, and also the committed bucket when that bucket is enabled. A yellow frame charges only the peak bucket. A discarded frame charges neither.
- R9: With the committed bucket enabled and coupling set, the part of a committed drain that exceeds the committed fill is also taken off the peak fill on the same tick.
- R10: A force pulse sets that bucket's fill to all ones (8388607). From then on every frame judged against that bucket fails it until the bucket has drained.
- R11: A peak rate of 65535 with a peak burst of 0 disables policing: every frame is green and neither bucket is charged.
- R12: With the committed enable low, the committed bucket has no effect on any verdict and is never charged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Metering mode: 0 line, 1 data, 2 coarse frame, 3 fine frame |
| cfg_gap | input | 5 | Gap bytes added per frame in line mode |
| cfg_pk_rate | input | 16 | Peak drain rate |
| cfg_pk_burst | input | 7 | Peak burst value |
| cfg_cm_en | input | 1 | Committed bucket enable |
| cfg_couple | input | 1 | Pass unused committed drain to the peak bucket |
| cfg_cm_rate | input | 16 | Committed drain rate |
| cfg_cm_burst | input | 6 | Committed burst value |
| pk_fill_force | input | 1 | Load the peak fill with all ones |
| cm_fill_force | input | 1 | Load the committed fill with all ones |
| drain_tick | input | 1 | Periodic drain strobe |
| frame_start | input | 1 | Frame arrival pulse |
| frame_len | input | LEN_W | Frame length in bytes |
| verdict_valid | output | 1 | Verdict available |
| verdict | output | 2 | 0 green, 1 yellow, 2 discard |

## Verification
Back-to-back frames of one length against a single bucket expose the overshoot limit and the exact frame at which discards begin. The same length is sent in line and data mode, sized so that only the gap charge moves the second frame across the limit. A mixed dual-bucket run yields green, then yellow, then discard, and shows which buckets each colour charges. Tick-only stretches in the fine frame mode, with and without coupling, and in the disable setting, show drain gating, the transfer of surplus drain to the peak bucket, and the absence of any charge.

// File: rtl/dlb_policer_pkg.sv
package dlb_policer_pkg;
    localparam int FILL_W = 23;
    localparam int BYTE_UNIT_SHIFT = 12;
    localparam int HI_BURST_UNIT = 328;
    localparam int LO_BURST_UNIT = 3;
    localparam int FRAME_CHARGE = 10;

    typedef enum logic [1:0] {
        MODE_LINE   = 2'd0,
        MODE_DATA   = 2'd1,
        MODE_FRM_HI = 2'd2,
        MODE_FRM_LO = 2'd3
    } meter_mode_e;

    typedef enum logic [1:0] {
        VERD_GREEN   = 2'd0,
        VERD_YELLOW  = 2'd1,
        VERD_DISCARD = 2'd2
    } verdict_e;
endpackage

// File: rtl/dlb_meter_scale.sv
module dlb_meter_scale
    import dlb_policer_pkg::*;
#(
    parameter int LEN_W     = 14,
    parameter int BIT_DRAIN = 25,
    parameter int FRM_DRAIN = 2,
    parameter int LO_DIV    = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  meter_mode_e       mode,
    input  logic [4:0]        gap,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic [15:0]       pk_rate,
    input  logic [6:0]        pk_burst,
    input  logic [15:0]       cm_rate,
    input  logic [5:0]        cm_burst,
    input  logic              drain_tick,
    output logic [FILL_W-1:0] pk_drain,
    output logic [FILL_W-1:0] cm_drain,
    output logic [FILL_W-1:0] pk_limit,
    output logic [FILL_W-1:0] cm_limit,
    output logic [FILL_W-1:0] charge
);
    localparam int CNT_W = (LO_DIV > 1) ? $clog2(LO_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LO_DIV - 1);
    localparam logic [FILL_W-1:0] STEP_BIT = FILL_W'(BIT_DRAIN);
    localparam logic [FILL_W-1:0] STEP_FRM = FILL_W'(FRM_DRAIN);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } scale_state_t;

    scale_state_t st_d, st_q;
    logic drain_en;
    logic [FILL_W-1:0] step;

    always_comb begin
        st_d = st_q;
        if (drain_tick) begin
            st_d.cnt = (st_q.cnt == CNT_LAST) ? '0 : st_q.cnt + 1'b1;
        end
        drain_en = drain_tick && ((mode != MODE_FRM_LO) || (st_q.cnt == CNT_LAST));
        step = (mode == MODE_LINE || mode == MODE_DATA) ? STEP_BIT : STEP_FRM;
        pk_drain = drain_en ? FILL_W'(pk_rate) * step : '0;
        cm_drain = drain_en ? FILL_W'(cm_rate) * step : '0;
        unique case (mode)
            MODE_LINE, MODE_DATA: begin
                pk_limit = FILL_W'(pk_burst) << BYTE_UNIT_SHIFT;
                cm_limit = FILL_W'(cm_burst) << BYTE_UNIT_SHIFT;
            end
            MODE_FRM_HI: begin
                pk_limit = FILL_W'(pk_burst) * FILL_W'(HI_BURST_UNIT);
                cm_limit = FILL_W'(cm_burst) * FILL_W'(HI_BURST_UNIT);
            end
            default: begin
                pk_limit = FILL_W'(pk_burst) * FILL_W'(LO_BURST_UNIT);
                cm_limit = FILL_W'(cm_burst) * FILL_W'(LO_BURST_UNIT);
            end
        endcase
        unique case (mode)
            MODE_LINE: charge = FILL_W'(frame_len) + FILL_W'(gap);
            MODE_DATA: charge = FILL_W'(frame_len);
            default:   charge = FILL_W'(FRAME_CHARGE);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_no_tick_no_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !drain_tick |-> (pk_drain == '0 && cm_drain == '0));

    assert_lo_div_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FRM_LO && drain_tick && pk_drain != '0) |=> (st_q.cnt == '0));
endmodule

// File: rtl/dlb_bucket.sv
module dlb_bucket
    import dlb_policer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FILL_W-1:0] drain_amt,
    input  logic [FILL_W-1:0] extra_drain,
    input  logic [FILL_W-1:0] limit,
    input  logic [FILL_W-1:0] charge_amt,
    input  logic              charge_en,
    input  logic              force_full,
    output logic              conform,
    output logic [FILL_W-1:0] spare
);
    typedef struct packed {
        logic [FILL_W-1:0] fill;
    } bucket_state_t;

    bucket_state_t st_d, st_q;
    logic [FILL_W:0] total;
    logic [FILL_W:0] sum;
    logic [FILL_W-1:0] drained;

    always_comb begin
        st_d = st_q;
        total = {1'b0, drain_amt} + {1'b0, extra_drain};
        drained = (total >= {1'b0, st_q.fill}) ? '0 : st_q.fill - total[FILL_W-1:0];
        spare = (drain_amt > st_q.fill) ? drain_amt - st_q.fill : '0;
        sum = {1'b0, drained} + (charge_en ? {1'b0, charge_amt} : '0);
        st_d.fill = sum[FILL_W] ? '1 : sum[FILL_W-1:0];
        if (force_full) st_d.fill = '1;
        conform = (st_q.fill <= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_force_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        force_full |=> (st_q.fill == '1));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_full && !charge_en && drain_amt == '0 && extra_drain == '0) |=> $stable(st_q.fill));

    assert_drain_only_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_full && !charge_en) |=> (st_q.fill <= $past(st_q.fill)));

    assert_charge_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_full && charge_en && charge_amt != '0 && drain_amt == '0 &&
         extra_drain == '0 && st_q.fill != '1) |=> (st_q.fill > $past(st_q.fill)));
endmodule

// File: rtl/dlb_policer.sv
module dlb_policer
    import dlb_policer_pkg::*;
#(
    parameter int LEN_W     = 14,
    parameter int BIT_DRAIN = 25,
    parameter int FRM_DRAIN = 2,
    parameter int LO_DIV    = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_mode,
    input  logic [4:0]       cfg_gap,
    input  logic [15:0]      cfg_pk_rate,
    input  logic [6:0]       cfg_pk_burst,
    input  logic             cfg_cm_en,
    input  logic             cfg_couple,
    input  logic [15:0]      cfg_cm_rate,
    input  logic [5:0]       cfg_cm_burst,
    input  logic             pk_fill_force,
    input  logic             cm_fill_force,
    input  logic             drain_tick,
    input  logic             frame_start,
    input  logic [LEN_W-1:0] frame_len,
    output logic             verdict_valid,
    output logic [1:0]       verdict
);
    typedef struct packed {
        logic     valid;
        verdict_e verdict;
    } out_state_t;

    out_state_t st_d, st_q;
    meter_mode_e mode;
    logic [FILL_W-1:0] pk_drain, cm_drain, pk_limit, cm_limit, charge;
    logic [FILL_W-1:0] cm_spare, pk_extra, cm_extra_unused;
    logic pk_conform, cm_conform;
    logic bypass, cm_ok, pk_charge_en, cm_charge_en;

    assign mode = meter_mode_e'(cfg_mode);
    assign cm_extra_unused = '0;

    dlb_meter_scale #(
        .LEN_W(LEN_W), .BIT_DRAIN(BIT_DRAIN), .FRM_DRAIN(FRM_DRAIN), .LO_DIV(LO_DIV)
    ) u_scale (
        .clk(clk), .rst_n(rst_n), .mode(mode), .gap(cfg_gap), .frame_len(frame_len),
        .pk_rate(cfg_pk_rate), .pk_burst(cfg_pk_burst), .cm_rate(cfg_cm_rate),
        .cm_burst(cfg_cm_burst), .drain_tick(drain_tick),
        .pk_drain(pk_drain), .cm_drain(cm_drain), .pk_limit(pk_limit),
        .cm_limit(cm_limit), .charge(charge)
    );

    dlb_bucket u_cm (
        .clk(clk), .rst_n(rst_n), .drain_amt(cm_drain), .extra_drain(cm_extra_unused),
        .limit(cm_limit), .charge_amt(charge), .charge_en(cm_charge_en),
        .force_full(cm_fill_force), .conform(cm_conform), .spare(cm_spare)
    );

    logic [FILL_W-1:0] pk_spare_unused;

    dlb_bucket u_pk (
        .clk(clk), .rst_n(rst_n), .drain_amt(pk_drain), .extra_drain(pk_extra),
        .limit(pk_limit), .charge_amt(charge), .charge_en(pk_charge_en),
        .force_full(pk_fill_force), .conform(pk_conform), .spare(pk_spare_unused)
    );

    always_comb begin
        st_d = st_q;
        bypass = (&cfg_pk_rate) && (cfg_pk_burst == '0);
        cm_ok = cm_conform || !cfg_cm_en;
        pk_extra = (cfg_cm_en && cfg_couple) ? cm_spare : '0;
        pk_charge_en = frame_start && !bypass && pk_conform;
        cm_charge_en = pk_charge_en && cfg_cm_en && cm_conform;
        st_d.valid = frame_start;
        if (frame_start) begin
            if (bypass)          st_d.verdict = VERD_GREEN;
            else if (!pk_conform) st_d.verdict = VERD_DISCARD;
            else if (cm_ok)      st_d.verdict = VERD_GREEN;
            else                 st_d.verdict = VERD_YELLOW;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{valid: 1'b0, verdict: VERD_GREEN};
        else        st_q <= st_d;
    end

    assign verdict_valid = st_q.valid;
    assign verdict = st_q.verdict;

    assert_verdict_follows_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> verdict_valid);

    assert_no_spurious_verdict_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> !verdict_valid);

    assert_peak_fail_discard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !bypass && !pk_conform) |=> (verdict == VERD_DISCARD));

    assert_bypass_green_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && bypass) |=> (verdict == VERD_GREEN));

    assert_cm_off_no_yellow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !cfg_cm_en) |=> (verdict != VERD_YELLOW));
endmodule

// File: tb/tb_dlb_policer.sv
module tb_dlb_policer;
    localparam int LEN_W = 14;
    localparam int BIT_DRAIN = 25;
    localparam int FRM_DRAIN = 2;
    localparam int LO_DIV = 4;
    localparam int MAXF = 8388607;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cfg_mode = 2'd1;
    logic [4:0] cfg_gap = 5'd20;
    logic [15:0] cfg_pk_rate = '0;
    logic [6:0] cfg_pk_burst = '0;
    logic cfg_cm_en = 1'b0;
    logic cfg_couple = 1'b0;
    logic [15:0] cfg_cm_rate = '0;
    logic [5:0] cfg_cm_burst = '0;
    logic pk_fill_force = 1'b0;
    logic cm_fill_force = 1'b0;
    logic drain_tick = 1'b0;
    logic frame_start = 1'b0;
    logic [LEN_W-1:0] frame_len = '0;
    logic verdict_valid;
    logic [1:0] verdict;

    always #4 clk = ~clk;

    dlb_policer #(.LEN_W(LEN_W), .BIT_DRAIN(BIT_DRAIN), .FRM_DRAIN(FRM_DRAIN), .LO_DIV(LO_DIV)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_gap(cfg_gap),
        .cfg_pk_rate(cfg_pk_rate), .cfg_pk_burst(cfg_pk_burst), .cfg_cm_en(cfg_cm_en),
        .cfg_couple(cfg_couple), .cfg_cm_rate(cfg_cm_rate), .cfg_cm_burst(cfg_cm_burst),
        .pk_fill_force(pk_fill_force), .cm_fill_force(cm_fill_force),
        .drain_tick(drain_tick), .frame_start(frame_start), .frame_len(frame_len),
        .verdict_valid(verdict_valid), .verdict(verdict)
    );

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;
    string cur_req = "R1";
    int m_pk = 0, m_cm = 0, m_cnt = 0;
    int n_green = 0, n_yellow = 0, n_disc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Behavioural reference: predicts the outputs after the next edge.
    task automatic step(input bit tk, input bit fs, input int len, input bit fpk, input bit fcm);
        int stp, pdr, cdr, plim, clim, chg, spare, unit, cm_old, ev;
        bit den, byp, pk_ok, cm_ok;
        den = tk && (cfg_mode != 2'd3 || m_cnt == LO_DIV - 1);
        if (tk) m_cnt = (m_cnt + 1) % LO_DIV;
        stp = (cfg_mode < 2) ? BIT_DRAIN : FRM_DRAIN;
        pdr = den ? int'(cfg_pk_rate) * stp : 0;
        cdr = den ? int'(cfg_cm_rate) * stp : 0;
        unit = (cfg_mode < 2) ? 4096 : (cfg_mode == 2 ? 328 : 3);
        plim = int'(cfg_pk_burst) * unit;
        clim = int'(cfg_cm_burst) * unit;
        chg = (cfg_mode == 0) ? len + int'(cfg_gap) : (cfg_mode == 1 ? len : 10);
        byp = (cfg_pk_rate == 16'hFFFF) && (cfg_pk_burst == 0);
        pk_ok = m_pk <= plim;
        cm_ok = !cfg_cm_en || (m_cm <= clim);
        if (byp) ev = 0; else if (!pk_ok) ev = 2; else if (cm_ok) ev = 0; else ev = 1;
        cm_old = m_cm;
        m_cm = (cdr >= m_cm) ? 0 : m_cm - cdr;
        spare = (cdr > cm_old) ? cdr - cm_old : 0;
        if (!(cfg_cm_en && cfg_couple)) spare = 0;
        m_pk = (pdr + spare >= m_pk) ? 0 : m_pk - pdr - spare;
        if (fs && !byp && ev != 2) begin
            m_pk = (m_pk + chg > MAXF) ? MAXF : m_pk + chg;
            if (ev == 0 && cfg_cm_en) m_cm = (m_cm + chg > MAXF) ? MAXF : m_cm + chg;
        end
        if (fpk) m_pk = MAXF;
        if (fcm) m_cm = MAXF;
        drain_tick = tk; frame_start = fs; frame_len = LEN_W'(len);
        pk_fill_force = fpk; cm_fill_force = fcm;
        @(posedge clk);
        @(negedge clk);
        if (fs) begin
            check(verdict_valid === 1'b1, cur_req, int'(verdict_valid), 1);
            check(verdict === 2'(ev), cur_req, int'(verdict), ev);
            if (ev == 0) n_green++; else if (ev == 1) n_yellow++; else n_disc++;
        end else begin
            check(verdict_valid === 1'b0, cur_req, int'(verdict_valid), 0);
        end
        drain_tick = 0; frame_start = 0; pk_fill_force = 0; cm_fill_force = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_pk = 0; m_cm = 0; m_cnt = 0;
        check(verdict_valid === 1'b0, "R1", int'(verdict_valid), 0);
    endtask

    task automatic frames(input int n, input int len);
        for (int i = 0; i < n; i++) step(0, 1, len, 0, 0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0);
    endtask

    initial begin
        while (cyc < 150000) @(posedge clk);
        check(0, "watchdog", cyc, 150000);
        finish_run();
    end

    initial begin
        int g0;
        // R1: reset state, first frame accepted with zero limit
        cur_req = "R1";
        cfg_mode = 2'd1; cfg_pk_rate = 0; cfg_pk_burst = 0;
        do_reset();
        frames(1, 64);
        check(n_green == 1, "R1", n_green, 1);

        // R3: overshoot against a single bucket
        cur_req = "R3";
        do_reset();
        cfg_pk_burst = 1; cfg_pk_rate = 0;
        n_disc = 0;
        frames(5, 1500);
        check(n_disc == 2, "R3", n_disc, 2);

        // R4: line versus data charge
        cur_req = "R4";
        do_reset(); cfg_mode = 2'd1;
        frames(1, 4080); n_disc = 0; frames(1, 16);
        check(n_disc == 0, "R4 data", n_disc, 0);
        do_reset(); cfg_mode = 2'd0; cfg_gap = 5'd20;
        frames(1, 4080); n_disc = 0; frames(1, 16);
        check(n_disc == 1, "R4 line", n_disc, 1);

        // R5: frame-mode burst units
        cur_req = "R5";
        do_reset(); cfg_mode = 2'd2; cfg_pk_burst = 1;
        n_green = 0; frames(40, 64);
        check(n_green == 33, "R5 hi", n_green, 33);
        do_reset(); cfg_mode = 2'd3; cfg_pk_burst = 4;
        n_green = 0; frames(4, 64);
        check(n_green == 2, "R5 lo", n_green, 2);

        // R6: drain, including fine-mode tick division
        cur_req = "R6";
        do_reset(); cfg_mode = 2'd1; cfg_pk_burst = 1; cfg_pk_rate = 10;
        frames(4, 1500);
        for (int i = 0; i < 12; i++) begin ticks(1); step(0, 1, 100, 0, 0); end
        do_reset(); cfg_mode = 2'd3; cfg_pk_burst = 0; cfg_pk_rate = 5;
        frames(2, 64);
        for (int i = 0; i < 10; i++) begin ticks(1); step(0, 1, 64, 0, 0); end

        // R7, R8: dual bucket colours and charging
        cur_req = "R7";
        do_reset(); cfg_mode = 2'd1; cfg_cm_en = 1; cfg_cm_burst = 1; cfg_cm_rate = 0;
        cfg_pk_burst = 3; cfg_pk_rate = 0;
        n_green = 0; n_yellow = 0; n_disc = 0;
        frames(6, 3000);
        check(n_green == 2 && n_yellow == 3 && n_disc == 1, "R7", n_yellow, 3);
        cur_req = "R8";
        cfg_pk_rate = 20; cfg_cm_rate = 5;
        for (int i = 0; i < 30; i++) begin ticks(2); step(0, 1, 700 + 37 * i, 0, 0); end

        // R9: coupling moves surplus committed drain to the peak bucket
        cur_req = "R9";
        do_reset(); cfg_cm_en = 1; cfg_couple = 1; cfg_cm_rate = 40; cfg_cm_burst = 1;
        cfg_pk_rate = 0; cfg_pk_burst = 1;
        frames(2, 3000); ticks(12);
        n_disc = 0; frames(1, 100);
        check(n_disc == 0, "R9 coupled", n_disc, 0);
        do_reset(); cfg_couple = 0;
        frames(2, 3000); ticks(12);
        n_disc = 0; frames(1, 100);
        check(n_disc == 1, "R9 uncoupled", n_disc, 1);

        // R10: forced full buckets
        cur_req = "R10";
        do_reset(); cfg_cm_en = 1; cfg_cm_burst = 60; cfg_pk_burst = 60;
        cfg_cm_rate = 0; cfg_pk_rate = 0;
        step(0, 0, 0, 0, 1);
        n_yellow = 0; frames(2, 500);
        check(n_yellow == 2, "R10 committed", n_yellow, 2);
        step(0, 0, 0, 1, 0);
        n_disc = 0; frames(2, 500);
        check(n_disc == 2, "R10 peak", n_disc, 2);

        // R11: disable setting charges nothing
        cur_req = "R11";
        do_reset(); cfg_cm_en = 1; cfg_cm_burst = 0; cfg_cm_rate = 0;
        cfg_pk_rate = 16'hFFFF; cfg_pk_burst = 0;
        n_green = 0; frames(20, 9000);
        check(n_green == 20, "R11", n_green, 20);
        cfg_pk_rate = 0;
        g0 = n_green; frames(1, 64);
        check(n_green == g0 + 1, "R11 no charge", n_green, g0 + 1);

        // R12: committed bucket off
        cur_req = "R12";
        do_reset(); cfg_cm_en = 0; cfg_cm_burst = 0; cfg_pk_burst = 2;
        step(0, 0, 0, 0, 1);
        n_yellow = 0; n_green = 0; frames(4, 3000);
        check(n_yellow == 0 && n_green == 3, "R12", n_green, 3);

        // R2: alternating frames and idles
        cur_req = "R2";
        do_reset(); cfg_pk_burst = 5; cfg_pk_rate = 30;
        for (int i = 0; i < 20; i++) begin step(0, 1, 900, 0, 0); step(1, 0, 0, 0, 0); end

        finish_run();
    end
endmodule